// File: doc/BRIEF.md
# Warp Issue Scheduler

This block picks which resident warp of a streaming multiprocessor issues next. Every cycle it takes per-warp status: the warp is resident, it waits on an operand, it waits on an instruction fetch, and it may pair its next two instructions. It also takes the execution-unit class that each warp's next instruction, and the instruction after it, will use, and one busy bit for each unit class. From these it forms the set of warps that can issue. It then takes one warp from that set in round-robin order and reports whether one or two of its instructions go out.

Each warp keeps its own registers for its whole lifetime, so moving to another warp costs nothing. The scheduler may issue from a different warp on every cycle. All outputs are registered. They show the decision made from the inputs seen at the previous rising clock edge. Decode, the register file and the execution pipelines are outside this block.

Top module: `warp_issue_sched`

## Requirements
- R1: Warp w is eligible when it is resident, has no operand wait, has no fetch wait, and the busy bit indexed by its first unit class is clear. Warp w's first unit class sits in `unit_cls[w*UNIT_W +: UNIT_W]`, and class c is busy when `unit_busy[c]` is 1.
- R2: A warp whose resident bit is 0 is never eligible, whatever its stall bits say.
- R3: When some warp is eligible, the scheduler issues the first eligible warp found by searching upward, with wrap-around, from the warp after the last one issued. After reset the search starts at warp 0.
- R4: The issue count is 2 when the chosen warp's pair bit is set and the busy bit of its second unit class (`unit_cls2[w*UNIT_W +: UNIT_W]`) is clear. Otherwise it is 1.
- R5: When no warp is eligible, `issue_valid` is 0, `issue_count` is 0, `issue_warp` is 0, and the round-robin position does not change.
- R6: Consecutive cycles may issue from different warps, with no idle cycle between them.
- R7: `elig_vec`, `issue_valid`, `issue_warp` and `issue_count` change one clock after the inputs they depend on.
- R8: While reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| resident | input | NUM_WARPS | Warp holds a slot on the multiprocessor |
| dep_wait | input | NUM_WARPS | Warp waits on an operand |
| fetch_wait | input | NUM_WARPS | Warp waits on an instruction fetch |
| pair_ok | input | NUM_WARPS | Next two instructions may issue together |
| unit_cls | input | NUM_WARPS*UNIT_W | Unit class of each warp's next instruction |
| unit_cls2 | input | NUM_WARPS*UNIT_W | Unit class of each warp's second instruction |
| unit_busy | input | NUM_UNITS | Busy bit per unit class |
| issue_valid | output | 1 | A warp issued this cycle |
| issue_warp | output | ID_W | Index of the issued warp |
| issue_count | output | 2 | Instructions issued: 0, 1 or 2 |
| elig_vec | output | NUM_WARPS | Eligible warps for this decision |

## Verification
Random cycles mix resident, stall and busy bits at densities where the eligible set is often sparse and sometimes empty. This tells correct round-robin order apart from fixed priority, and shows the pointer holding over idle cycles. Directed cycles cover five cases:
- A lone eligible warp at the top index, which checks the wrap-around.
- Non-resident warps with all stall bits clear, which must stay ineligible.
- A pairable warp whose second unit is busy, which must drop to a count of 1.
- All warps eligible over consecutive cycles, which must issue a new warp each cycle.
- A fully stalled cycle, which must leave the next pick where it was.

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
  parameter int NUM_WARPS = 48,
  parameter int NUM_UNITS = 4,
  localparam int UNIT_W = $clog2(NUM_UNITS),
  localparam int ID_W = $clog2(NUM_WARPS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_WARPS-1:0]        resident,
  input  logic [NUM_WARPS-1:0]        dep_wait,
  input  logic [NUM_WARPS-1:0]        fetch_wait,
  input  logic [NUM_WARPS-1:0]        pair_ok,
  input  logic [NUM_WARPS*UNIT_W-1:0] unit_cls,
  input  logic [NUM_WARPS*UNIT_W-1:0] unit_cls2,
  input  logic [NUM_UNITS-1:0]        unit_busy,
  output logic                        issue_valid,
  output logic [ID_W-1:0]             issue_warp,
  output logic [1:0]                  issue_count,
  output logic [NUM_WARPS-1:0]        elig_vec
);

  logic [NUM_WARPS-1:0] elig_c, dual_c;
  logic [ID_W-1:0]      last_q, pick;
  logic                 found;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    assign elig_c[w] = resident[w] & ~dep_wait[w] & ~fetch_wait[w]
                     & ~unit_busy[unit_cls[w*UNIT_W +: UNIT_W]];
    assign dual_c[w] = pair_ok[w] & ~unit_busy[unit_cls2[w*UNIT_W +: UNIT_W]];
  end

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < NUM_WARPS; k++) begin
      int idx;
      idx = (int'(last_q) + 1 + k) % NUM_WARPS;
      if (!found && elig_c[idx]) begin
        found = 1'b1;
        pick  = ID_W'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q      <= ID_W'(NUM_WARPS - 1);
      issue_valid <= 1'b0;
      issue_warp  <= '0;
      issue_count <= 2'd0;
      elig_vec    <= '0;
    end else begin
      elig_vec    <= elig_c;
      issue_valid <= found;
      issue_warp  <= pick;
      issue_count <= !found ? 2'd0 : (dual_c[pick] ? 2'd2 : 2'd1);
      if (found) last_q <= pick;
    end
  end

endmodule

// File: rtl/warp_issue_sched_chk.sv
module warp_issue_sched_chk #(
  parameter int NUM_WARPS = 48,
  parameter int NUM_UNITS = 4,
  localparam int UNIT_W = $clog2(NUM_UNITS),
  localparam int ID_W = $clog2(NUM_WARPS)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NUM_WARPS-1:0]        resident,
  input logic [NUM_WARPS-1:0]        pair_ok,
  input logic                        issue_valid,
  input logic [ID_W-1:0]             issue_warp,
  input logic [1:0]                  issue_count,
  input logic [NUM_WARPS-1:0]        elig_vec
);
  logic [NUM_WARPS-1:0] res_q, pair_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q  <= '0;
      pair_q <= '0;
    end else begin
      res_q  <= resident;
      pair_q <= pair_ok;
    end
  end

  a_r2_nonresident_never_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    (elig_vec & ~res_q) == '0);
  a_r3_pick_in_elig_set: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> elig_vec[issue_warp]);
  a_r4_pair_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_count == 2'd2) |-> pair_q[issue_warp]);
  a_r4_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (issue_count == 2'd1 || issue_count == 2'd2));
  a_r5_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |-> (issue_count == 2'd0 && elig_vec == '0 && issue_warp == '0));
  a_r5_valid_tracks_set: assert property (@(posedge clk) disable iff (!rst_n)
    (elig_vec != '0) |-> issue_valid);
endmodule

bind warp_issue_sched warp_issue_sched_chk #(.NUM_WARPS(NUM_WARPS), .NUM_UNITS(NUM_UNITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .resident(resident), .pair_ok(pair_ok),
  .issue_valid(issue_valid), .issue_warp(issue_warp),
  .issue_count(issue_count), .elig_vec(elig_vec));

// File: tb/warp_issue_sched_tb.sv
module warp_issue_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 48;
  localparam int NU = 4;
  localparam int UW = 2;
  localparam int IW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NW-1:0] resident = '0, dep_wait = '0, fetch_wait = '0, pair_ok = '0;
  logic [NW*UW-1:0] unit_cls = '0, unit_cls2 = '0;
  logic [NU-1:0] unit_busy = '0;
  logic issue_valid;
  logic [IW-1:0] issue_warp;
  logic [1:0] issue_count;
  logic [NW-1:0] elig_vec;

  int checks = 0, fails = 0;
  int last_ref = NW - 1;
  int prev_warp = -1;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  warp_issue_sched #(.NUM_WARPS(NW), .NUM_UNITS(NU)) dut_i (
    .clk(clk), .rst_n(rst_n), .resident(resident), .dep_wait(dep_wait),
    .fetch_wait(fetch_wait), .pair_ok(pair_ok), .unit_cls(unit_cls),
    .unit_cls2(unit_cls2), .unit_busy(unit_busy), .issue_valid(issue_valid),
    .issue_warp(issue_warp), .issue_count(issue_count), .elig_vec(elig_vec));

  function automatic logic [NW-1:0] ref_elig();
    logic [NW-1:0] e;
    for (int w = 0; w < NW; w++)
      e[w] = resident[w] && !dep_wait[w] && !fetch_wait[w] && !unit_busy[unit_cls[w*UW +: UW]];
    return e;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // inputs already driven at a negedge; outputs compared one negedge later (R7)
  task automatic step(input bit check_switch);
    logic [NW-1:0] e;
    int exp_w, exp_c;
    bit exp_v;
    e = ref_elig();
    exp_v = 0; exp_w = 0; exp_c = 0;
    for (int k = 0; k < NW; k++) begin
      int i;
      i = (last_ref + 1 + k) % NW;
      if (!exp_v && e[i]) begin exp_v = 1; exp_w = i; end
    end
    if (exp_v) exp_c = (pair_ok[exp_w] && !unit_busy[unit_cls2[exp_w*UW +: UW]]) ? 2 : 1;
    @(negedge clk);
    chk(elig_vec == e, "R1/R2 elig_vec", int'($countones(elig_vec)), int'($countones(e)));
    chk(issue_valid == exp_v, "R5 issue_valid", int'(issue_valid), int'(exp_v));
    chk(int'(issue_warp) == exp_w, "R3 issue_warp", int'(issue_warp), exp_w);
    chk(int'(issue_count) == exp_c, "R4 issue_count", int'(issue_count), exp_c);
    if (check_switch && prev_warp >= 0)
      chk(issue_valid && int'(issue_warp) != prev_warp, "R6 back-to-back switch", int'(issue_warp), (prev_warp + 1) % NW);
    prev_warp = exp_v ? exp_w : -1;
    if (exp_v) last_ref = exp_w;
  endtask

  task automatic clear_all();
    resident = '0; dep_wait = '0; fetch_wait = '0; pair_ok = '0;
    unit_cls = '0; unit_cls2 = '0; unit_busy = '0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    resident = '1;
    repeat (3) @(negedge clk);
    chk(!issue_valid && issue_count == 0 && issue_warp == 0 && elig_vec == '0, "R8 reset outputs",
        int'(issue_valid), 0);
    rst_n = 1'b1;
    step(0);                               // R3: first pick is warp 0 after reset
    chk(last_ref == 0, "R3 start at warp 0", last_ref, 0);
    // R2: non-resident warps with clear stalls
    clear_all(); resident[5] = 1'b1; step(0);
    chk(int'(issue_warp) == 5, "R2 only resident issues", int'(issue_warp), 5);
    // R5: empty set, pointer must hold
    clear_all(); step(0);
    resident = '1; step(0);
    chk(int'(issue_warp) == 6, "R5 pointer held over idle", int'(issue_warp), 6);
    // R3 wrap: only top warp, then only warp 0
    clear_all(); resident[NW-1] = 1'b1; step(0);
    clear_all(); resident[0] = 1'b1; resident[NW-2] = 1'b1; step(0);
    chk(int'(issue_warp) == 0, "R3 wrap to warp 0", int'(issue_warp), 0);
    // R4: pair with second unit busy, then free
    clear_all(); resident[1] = 1'b1; pair_ok[1] = 1'b1;
    unit_cls2[1*UW +: UW] = 2'd3; unit_busy[3] = 1'b1; step(0);
    chk(issue_count == 2'd1, "R4 busy second unit", int'(issue_count), 1);
    unit_busy = '0; step(0);
    chk(issue_count == 2'd2, "R4 dual issue", int'(issue_count), 2);
    // R1: first unit busy blocks the warp
    clear_all(); resident[9] = 1'b1; unit_cls[9*UW +: UW] = 2'd2; unit_busy[2] = 1'b1; step(0);
    chk(!issue_valid, "R1 busy unit blocks", int'(issue_valid), 0);
    // R6: all eligible, consecutive cycles
    clear_all(); resident = '1; step(0);
    repeat (20) step(1);
    // random
    for (int n = 0; n < 400; n++) begin
      for (int w = 0; w < NW; w++) begin
        resident[w]   = ($urandom % 10) < 6;
        dep_wait[w]   = ($urandom % 10) < 5;
        fetch_wait[w] = ($urandom % 10) < 3;
        pair_ok[w]    = $urandom % 2;
        unit_cls[w*UW +: UW]  = UW'($urandom);
        unit_cls2[w*UW +: UW] = UW'($urandom);
      end
      unit_busy = NU'($urandom) & NU'($urandom);
      if (n % 37 == 0) dep_wait = '1;
      step(0);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); checks++; fails++; $display("FAIL watchdog actual=0 expected=1"); end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule